// File: doc/BRIEF.md
# Serial Peripheral Frame Shifter

This block is the bit engine of a serial peripheral master. It makes the serial clock from the core clock and moves one frame at a time between a parallel word and the serial data lines. A frame can use one line out and one line in (full duplex), or two or four lines together in one direction. The frame length, the bit order and the clock mode are picked per frame. A separate chip-select sequencer allows each frame to start through `grant`. The sequencer watches `busy` and `frame_done` to place its own select and gap timing around the frame. Transmit and receive queues sit outside the block.

The transmit word comes in on a valid/ready stream. `tx_ready` is high only while the engine is idle and `grant` is high. A word is taken on the clock edge where `tx_valid` and `tx_ready` are both high. The producer must hold `tx_valid` and `tx_data` steady until that edge. Every configuration input is sampled on that same edge and held for the whole frame, so the configuration may change while a frame runs. The received word comes back on a single-cycle `rx_valid` strobe with no back-pressure. The consumer must be able to take one word each time a frame ends.

Top module: `spi_frame_engine`

## Requirements
- R1: During a frame each half period of `sck` lasts `cfg_div`+1 core clock cycles, so the serial clock period is 2×(`cfg_div`+1). `cfg_div` is 12 bits wide, so values up to 4095 apply.
- R2: While idle, all four `dq_oe` bits are low and `busy` is low. `sck` rests at the level of `cfg_cpol`, following it one cycle later. `sck` is back at that level when a frame ends.
- R3: With `cfg_cpha`=0, incoming data is sampled on the leading edge of each serial clock cycle and outgoing data changes on the trailing edge. With `cfg_cpha`=1, outgoing data changes on every leading edge after the first, and incoming data is sampled on the trailing edge.
- R4: The lane codes in `cfg_lanes` are: 0 for one lane (out on `dq_out[0]`, in on `dq_in[1]`), 1 for two lanes (`dq[1]` carries the earlier bit of each pair), 2 for four lanes (`dq[3]` carries the earliest bit). Code 3 behaves as code 0. A frame of L bits over b lanes has exactly ceil(L/b) serial clock cycles.
- R5: With `cfg_lsb_first`=1, bit 0 of the word goes first on the lines and the first bit received lands in bit 0. With `cfg_lsb_first`=0, bit L-1 goes first and the first bit received lands in bit L-1.
- R6: `cfg_len` gives the frame length L in bits (1 to 8). A value of 0 or above 8 means 8. Bits of `rx_data` at or above L read as zero.
- R7: `tx_ready` is high only when idle with `grant` high. A frame starts only on an accepted handshake. Configuration changes made after acceptance do not affect the running frame.
- R8: With `cfg_tx_only`=1, no `rx_valid` is produced. The data lines of the chosen lane mode are driven for the whole frame (`dq_oe` = 0001, 0011 or 1111).
- R9: A two- or four-lane frame with `cfg_tx_only`=0 is a receive frame. `dq_oe` stays 0000 for the whole frame and the transmit word has no effect.
- R10: `frame_done` is high for exactly the one cycle after the last serial clock edge. `rx_valid` (when produced) is high in that same cycle. `busy` is high from the cycle after acceptance through that cycle, and low right after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_div | input | 12 | Half-period divisor minus one |
| cfg_cpol | input | 1 | Clock polarity (idle level of sck) |
| cfg_cpha | input | 1 | Clock phase |
| cfg_lanes | input | 2 | Lane mode: 0 one, 1 two, 2 four, 3 as one |
| cfg_lsb_first | input | 1 | 1 = least significant bit first |
| cfg_tx_only | input | 1 | 1 = transmit-only frame |
| cfg_len | input | 4 | Frame length in bits (0 or above 8 means 8) |
| grant | input | 1 | Sequencer allows a new frame |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Engine takes the word on this edge |
| tx_data | input | 8 | Transmit word |
| rx_valid | output | 1 | Received word strobe |
| rx_data | output | 8 | Received word |
| sck | output | 1 | Serial clock |
| dq_out | output | 4 | Data line output values |
| dq_oe | output | 4 | Per-line output enable |
| dq_in | input | 4 | Data line input values |
| busy | output | 1 | A frame is in progress |
| frame_done | output | 1 | Single-cycle end-of-frame pulse |

## Verification
The bench builds the block with its default parameters: a 12-bit divisor, an 8-bit word and a 4-bit length field. The 4-bit length field can hold values above the word width, so the clamp to 8 bits can be exercised. The full divisor range lets one frame run at divisor 4095, which reaches the top divisor bit. A slave model on the data lines runs frames in all four clock modes and all lane codes, including the reserved one. The frames cover both bit orders, partial final lane groups (lengths 5, 6 and 7), and configuration changes made in the middle of a frame.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;

  typedef enum logic [1:0] {
    FE_IDLE = 2'd0,
    FE_RUN  = 2'd1,
    FE_DONE = 2'd2
  } fe_state_e;

  typedef enum logic [1:0] {
    LANE_X1  = 2'd0,
    LANE_X2  = 2'd1,
    LANE_X4  = 2'd2,
    LANE_RSV = 2'd3
  } lane_mode_e;

  // Reserved code falls back to one lane
  function automatic lane_mode_e lane_norm(input logic [1:0] code);
    case (code)
      2'd1:    return LANE_X2;
      2'd2:    return LANE_X4;
      default: return LANE_X1;
    endcase
  endfunction

  // log2 of the bits moved per serial clock cycle
  function automatic logic [1:0] lane_log2(input lane_mode_e m);
    case (m)
      LANE_X2: return 2'd1;
      LANE_X4: return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

  // Output enables for a running frame
  function automatic logic [3:0] lane_oe(input lane_mode_e m, input logic tx_only);
    case (m)
      LANE_X2: return tx_only ? 4'b0011 : 4'b0000;
      LANE_X4: return tx_only ? 4'b1111 : 4'b0000;
      default: return 4'b0001;
    endcase
  endfunction

endpackage

// File: rtl/spi_fe_sckgen.sv
module spi_fe_sckgen #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             rest_level,
  input  logic [DIV_W-1:0] div,
  output logic             sck,
  output logic             edge_stb
);

  logic [DIV_W-1:0] cnt_q;
  logic             sck_q;

  assign edge_stb = run && (cnt_q == div);
  assign sck      = sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else if (!run) begin
      cnt_q <= '0;
      sck_q <= rest_level;
    end else if (edge_stb) begin
      cnt_q <= '0;
      sck_q <= ~sck_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/spi_fe_txshift.sv
module spi_fe_txshift
  import spi_fe_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic [WORD_W-1:0] word,
  input  logic [CNT_W-1:0]  ld_len,
  input  logic              ld_lsb_first,
  input  lane_mode_e        mode,
  output logic [3:0]        lanes
);

  localparam int IDX_W = $clog2(WORD_W);

  logic [WORD_W-1:0] sr_q;
  logic [WORD_W-1:0] staged;

  // Arrange the word so the first bit on the wire sits at the top
  always_comb begin
    staged = '0;
    for (int i = 0; i < WORD_W; i++) begin
      if (i < int'(ld_len)) begin
        if (ld_lsb_first)
          staged[IDX_W'(WORD_W - 1 - i)] = word[IDX_W'(i)];
        else
          staged[IDX_W'(WORD_W - int'(ld_len) + i)] = word[IDX_W'(i)];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (load) begin
      sr_q <= staged;
    end else if (shift) begin
      case (mode)
        LANE_X2: sr_q <= sr_q << 2;
        LANE_X4: sr_q <= sr_q << 4;
        default: sr_q <= sr_q << 1;
      endcase
    end
  end

  always_comb begin
    case (mode)
      LANE_X2: lanes = {2'b00, sr_q[WORD_W-1], sr_q[WORD_W-2]};
      LANE_X4: lanes = sr_q[WORD_W-1 -: 4];
      default: lanes = {3'b000, sr_q[WORD_W-1]};
    endcase
  end

endmodule

// File: rtl/spi_fe_rxshift.sv
module spi_fe_rxshift
  import spi_fe_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              sample,
  input  lane_mode_e        mode,
  input  logic [3:0]        dq_in,
  input  logic [CNT_W-1:0]  len,
  input  logic              lsb_first,
  input  logic [CNT_W:0]    tot_bits,
  output logic [WORD_W-1:0] word
);

  localparam int IDX_W = $clog2(WORD_W);

  logic [WORD_W-1:0] rs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= '0;
    end else if (clear) begin
      rs_q <= '0;
    end else if (sample) begin
      case (mode)
        LANE_X2: rs_q <= {rs_q[WORD_W-3:0], dq_in[1:0]};
        LANE_X4: rs_q <= {rs_q[WORD_W-5:0], dq_in[3:0]};
        default: rs_q <= {rs_q[WORD_W-2:0], dq_in[1]};
      endcase
    end
  end

  // Received stream bit j sits at rs_q[tot_bits-1-j]
  always_comb begin
    word = '0;
    for (int i = 0; i < WORD_W; i++) begin
      if (i < int'(len)) begin
        if (lsb_first)
          word[IDX_W'(i)] = rs_q[IDX_W'(int'(tot_bits) - 1 - i)];
        else
          word[IDX_W'(i)] = rs_q[IDX_W'(int'(tot_bits) - int'(len) + i)];
      end
    end
  end

endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
  import spi_fe_pkg::*;
#(
  parameter int DIV_W  = 12,
  parameter int WORD_W = 8,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic [1:0]        cfg_lanes,
  input  logic              cfg_lsb_first,
  input  logic              cfg_tx_only,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              grant,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [WORD_W-1:0] tx_data,
  output logic              rx_valid,
  output logic [WORD_W-1:0] rx_data,
  output logic              sck,
  output logic [3:0]        dq_out,
  output logic [3:0]        dq_oe,
  input  logic [3:0]        dq_in,
  output logic              busy,
  output logic              frame_done
);

  localparam int CNT_W  = $clog2(WORD_W + 1);
  localparam int EDGE_W = CNT_W + 1;

  fe_state_e         st_q;
  logic              accept;
  logic              edge_stb;
  logic              last_edge;
  logic              sample_stb;
  logic              shift_stb;

  logic [CNT_W-1:0]  len_eff;
  lane_mode_e        mode_in;
  logic [1:0]        lg_in;
  logic [EDGE_W-1:0] beats_in;

  logic [DIV_W-1:0]  div_q;
  logic              cpol_q;
  logic              cpha_q;
  lane_mode_e        mode_q;
  logic              lsb_q;
  logic              txo_q;
  logic [CNT_W-1:0]  len_q;
  logic [EDGE_W-1:0] edges_q;
  logic [EDGE_W-1:0] edge_cnt_q;
  logic [CNT_W:0]    tot_bits;

  // Length clamp and frame geometry from the live settings
  always_comb begin
    if (cfg_len == '0 || int'(cfg_len) > WORD_W)
      len_eff = CNT_W'(WORD_W);
    else
      len_eff = CNT_W'(cfg_len);
    mode_in  = lane_norm(cfg_lanes);
    lg_in    = lane_log2(mode_in);
    beats_in = (EDGE_W'(len_eff) + (EDGE_W'(1) << lg_in) - EDGE_W'(1)) >> lg_in;
  end

  assign tx_ready   = (st_q == FE_IDLE) && grant;
  assign accept     = tx_ready && tx_valid;
  assign busy       = (st_q != FE_IDLE);
  assign frame_done = (st_q == FE_DONE);
  assign rx_valid   = frame_done && !txo_q;
  assign dq_oe      = busy ? lane_oe(mode_q, txo_q) : 4'b0000;
  assign tot_bits   = (CNT_W + 1)'((edges_q >> 1) << lane_log2(mode_q));

  assign last_edge  = edge_stb && (edge_cnt_q == edges_q - EDGE_W'(1));
  assign sample_stb = edge_stb && (cpha_q ? edge_cnt_q[0] : !edge_cnt_q[0]);
  assign shift_stb  = edge_stb && (cpha_q ? (!edge_cnt_q[0] && edge_cnt_q != '0)
                                          : edge_cnt_q[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= FE_IDLE;
      div_q      <= '0;
      cpol_q     <= 1'b0;
      cpha_q     <= 1'b0;
      mode_q     <= LANE_X1;
      lsb_q      <= 1'b0;
      txo_q      <= 1'b0;
      len_q      <= CNT_W'(WORD_W);
      edges_q    <= EDGE_W'(2);
      edge_cnt_q <= '0;
    end else begin
      case (st_q)
        FE_IDLE: begin
          if (accept) begin
            st_q       <= FE_RUN;
            div_q      <= cfg_div;
            cpol_q     <= cfg_cpol;
            cpha_q     <= cfg_cpha;
            mode_q     <= mode_in;
            lsb_q      <= cfg_lsb_first;
            txo_q      <= cfg_tx_only;
            len_q      <= len_eff;
            edges_q    <= beats_in << 1;
            edge_cnt_q <= '0;
          end
        end
        FE_RUN: begin
          if (edge_stb) edge_cnt_q <= edge_cnt_q + EDGE_W'(1);
          if (last_edge) st_q <= FE_DONE;
        end
        default: st_q <= FE_IDLE;
      endcase
    end
  end

  spi_fe_sckgen #(.DIV_W(DIV_W)) u_sck (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (st_q == FE_RUN),
    .rest_level ((st_q == FE_IDLE) ? cfg_cpol : cpol_q),
    .div        (div_q),
    .sck        (sck),
    .edge_stb   (edge_stb)
  );

  spi_fe_txshift #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_tx (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (accept),
    .shift        (shift_stb),
    .word         (tx_data),
    .ld_len       (len_eff),
    .ld_lsb_first (cfg_lsb_first),
    .mode         (mode_q),
    .lanes        (dq_out)
  );

  spi_fe_rxshift #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (accept),
    .sample    (sample_stb && !txo_q),
    .mode      (mode_q),
    .dq_in     (dq_in),
    .len       (len_q),
    .lsb_first (lsb_q),
    .tot_bits  (tot_bits),
    .word      (rx_data)
  );

endmodule

// File: rtl/spi_frame_engine_chk.sv
module spi_frame_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_cpol,
  input logic       grant,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       rx_valid,
  input logic       sck,
  input logic [3:0] dq_oe,
  input logic       busy,
  input logic       frame_done
);

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  a_r7_ready_when_idle_granted: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (!busy && grant));

  a_r7_accept_starts_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> busy);

  a_r10_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  a_r10_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !busy);

  a_r8_rx_only_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> frame_done);

  a_r2_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (dq_oe == 4'b0000));

  a_r2_idle_sck_rest: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !busy && $past(!busy)) |-> (sck == $past(cfg_cpol)));

  a_r4_oe_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe == 4'b0000 || dq_oe == 4'b0001 || dq_oe == 4'b0011 || dq_oe == 4'b1111));

endmodule

bind spi_frame_engine spi_frame_engine_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_cpol   (cfg_cpol),
  .grant      (grant),
  .tx_valid   (tx_valid),
  .tx_ready   (tx_ready),
  .rx_valid   (rx_valid),
  .sck        (sck),
  .dq_oe      (dq_oe),
  .busy       (busy),
  .frame_done (frame_done)
);

// File: tb/spi_frame_engine_test.sv
module spi_frame_engine_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] cfg_div = '0;
  logic        cfg_cpol = 1'b0;
  logic        cfg_cpha = 1'b0;
  logic [1:0]  cfg_lanes = '0;
  logic        cfg_lsb_first = 1'b0;
  logic        cfg_tx_only = 1'b0;
  logic [3:0]  cfg_len = 4'd8;
  logic        grant = 1'b0;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic [7:0]  tx_data = '0;
  logic        rx_valid;
  logic [7:0]  rx_data;
  logic        sck;
  logic [3:0]  dq_out;
  logic [3:0]  dq_oe;
  logic [3:0]  dq_in = '0;
  logic        busy;
  logic        frame_done;

  always #5 clk = ~clk;

  spi_frame_engine uut (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_cpol(cfg_cpol),
    .cfg_cpha(cfg_cpha), .cfg_lanes(cfg_lanes), .cfg_lsb_first(cfg_lsb_first),
    .cfg_tx_only(cfg_tx_only), .cfg_len(cfg_len), .grant(grant),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_data(rx_data), .sck(sck), .dq_out(dq_out),
    .dq_oe(dq_oe), .dq_in(dq_in), .busy(busy), .frame_done(frame_done)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  always @(posedge clk) cyc = cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Current frame description shared with the slave model and monitor
  bit         in_frame = 0;
  int         f_b = 1;
  int         f_cpha = 0;
  int         f_edges = 0;
  int         f_div = 0;
  logic [3:0] exp_oe = '0;
  logic [7:0] slave_sr = '0;
  int         edge_k = 0;
  int         last_tog = 0;
  int         done_cyc = -1;
  bit         gap_bad = 0;
  bit         oe_bad = 0;
  logic [7:0] cap = '0;
  int         cap_n = 0;
  logic [7:0] rx_q[$];

  task automatic present();
    case (f_b)
      2:       dq_in = {2'b00, slave_sr[7:6]};
      4:       dq_in = slave_sr[7:4];
      default: dq_in = {2'b00, slave_sr[7], 1'b0};
    endcase
  endtask

  // Slave model: reacts to every serial clock transition
  always @(sck) begin
    if (in_frame) begin
      edge_k = edge_k + 1;
      if (cyc - last_tog != f_div + 1) gap_bad = 1;
      last_tog = cyc;
      if ((f_cpha == 1) ? (edge_k % 2 == 0) : (edge_k % 2 == 1)) begin
        for (int j = 0; j < f_b; j++) begin
          if (cap_n < 8) begin
            cap[cap_n] = (f_b == 1) ? dq_out[0] : dq_out[f_b - 1 - j];
            cap_n++;
          end
        end
      end
      if ((f_cpha == 1) ? (edge_k % 2 == 1 && edge_k > 1) : (edge_k % 2 == 0)) begin
        slave_sr = slave_sr << f_b;
        present();
      end
      if (edge_k == f_edges) done_cyc = cyc;
    end
  end

  // Monitor: output enables during frames and the receive scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy && dq_oe !== exp_oe) oe_bad = 1;
      if (rx_valid) begin
        if (rx_q.size() == 0) begin
          chk(0, "R8", "unexpected rx_valid", 1, 0);
        end else begin
          logic [7:0] e;
          e = rx_q.pop_front();
          chk(rx_data === e, "R3/R5/R6", "received word", rx_data, e);
        end
      end
    end
  end

  task automatic run_frame(input logic pol, input logic pha, input logic [1:0] ln,
                           input logic lsb, input logic txo, input logic [3:0] len,
                           input logic [11:0] dv, input logic [7:0] txw,
                           input logic [7:0] pat, input bit disturb);
    int L;
    int beats;
    logic [7:0] er;
    logic [7:0] got;
    logic [7:0] msk;
    @(negedge clk);
    cfg_cpol = pol; cfg_cpha = pha; cfg_lanes = ln; cfg_lsb_first = lsb;
    cfg_tx_only = txo; cfg_len = len; cfg_div = dv; tx_data = txw;
    L = (len == 0 || len > 8) ? 8 : int'(len);
    f_b = (ln == 2'd1) ? 2 : (ln == 2'd2) ? 4 : 1;
    beats = (L + f_b - 1) / f_b;
    f_edges = 2 * beats;
    f_cpha = int'(pha);
    f_div = int'(dv);
    exp_oe = (f_b == 1) ? 4'b0001 : !txo ? 4'b0000 : (f_b == 2) ? 4'b0011 : 4'b1111;
    edge_k = 0; cap = '0; cap_n = 0; gap_bad = 0; oe_bad = 0; done_cyc = -1;
    slave_sr = pat;
    present();
    msk = 8'((9'd1 << L) - 9'd1);
    if (!txo) begin
      er = '0;
      for (int i = 0; i < L; i++) begin
        if (lsb) er[i] = pat[7 - i];
        else     er[L - 1 - i] = pat[7 - i];
      end
      rx_q.push_back(er);
    end
    @(negedge clk);
    @(negedge clk);
    chk(sck === pol, "R2", "sck rest level before frame", sck, pol);
    grant = 1'b1; tx_valid = 1'b1;
    @(posedge clk);
    #1;
    last_tog = cyc;
    in_frame = 1;
    @(negedge clk);
    tx_valid = 1'b0; grant = 1'b0;
    if (disturb) begin
      cfg_lsb_first = ~lsb; cfg_div = 12'd0; cfg_len = 4'd1;
      cfg_lanes = 2'd2; cfg_tx_only = ~txo; cfg_cpha = ~pha;
    end
    while (!frame_done) @(negedge clk);
    in_frame = 0;
    chk(done_cyc == cyc, "R10", "frame_done cycle after last edge", done_cyc, cyc);
    chk(edge_k == f_edges, "R4", "serial clock edges per frame", edge_k, f_edges);
    chk(!gap_bad, "R1", "half period length", gap_bad, 0);
    chk(!oe_bad, (f_b > 1 && !txo) ? "R9" : "R8", "output enables in frame", oe_bad, 0);
    if (f_b == 1 || txo) begin
      got = '0;
      for (int i = 0; i < L; i++) begin
        if (lsb) got[i] = cap[i];
        else     got[L - 1 - i] = cap[i];
      end
      chk(got === (txw & msk), disturb ? "R7" : "R3/R5/R6", "transmitted bits",
          got, txw & msk);
    end
    @(negedge clk);
    chk(!busy && !frame_done && !rx_valid && sck === pol && dq_oe === 4'b0000,
        "R2/R10", "idle after frame", {busy, frame_done, sck, dq_oe}, {2'b00, pol, 4'b0000});
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(!busy && !tx_ready && !rx_valid && !frame_done && dq_oe === 4'b0000,
        "R2", "reset state", {busy, tx_ready, rx_valid, frame_done, dq_oe}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(sck === 1'b0, "R2", "sck after reset", sck, 0);

    // R7: a valid word with no grant is never taken
    tx_valid = 1'b1;
    begin
      bit bad;
      bad = 0;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (tx_ready || busy) bad = 1;
      end
      chk(!bad, "R7", "no start without grant", bad, 0);
    end
    tx_valid = 1'b0; grant = 1'b1;
    @(negedge clk);
    chk(tx_ready && !busy, "R7", "ready with grant and no word", {tx_ready, busy}, 2'b10);
    grant = 1'b0;

    //        pol   pha   ln     lsb   txo   len    div       tx     pat    dist
    run_frame(1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 4'd8,  12'd1,    8'hA5, 8'h3C, 0);
    run_frame(1'b1, 1'b1, 2'd0, 1'b1, 1'b0, 4'd8,  12'd2,    8'h5A, 8'hC3, 0);
    run_frame(1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 4'd5,  12'd0,    8'h1B, 8'hB8, 0);
    run_frame(1'b1, 1'b0, 2'd0, 1'b1, 1'b0, 4'd0,  12'd1,    8'h96, 8'hE1, 0);
    run_frame(1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 4'd8,  12'd1,    8'hFF, 8'h6D, 0);
    run_frame(1'b0, 1'b1, 2'd1, 1'b1, 1'b1, 4'd8,  12'd0,    8'hC6, 8'h00, 0);
    run_frame(1'b1, 1'b0, 2'd1, 1'b0, 1'b1, 4'd5,  12'd1,    8'h15, 8'h00, 0);
    run_frame(1'b1, 1'b1, 2'd2, 1'b0, 1'b0, 4'd6,  12'd3,    8'h00, 8'h9F, 0);
    run_frame(1'b0, 1'b0, 2'd2, 1'b0, 1'b1, 4'd12, 12'd1,    8'hD2, 8'h00, 0);
    run_frame(1'b0, 1'b1, 2'd2, 1'b1, 1'b0, 4'd7,  12'd2,    8'h00, 8'h5B, 0);
    run_frame(1'b0, 1'b0, 2'd3, 1'b1, 1'b0, 4'd3,  12'd1,    8'h05, 8'hA0, 0);
    run_frame(1'b1, 1'b0, 2'd0, 1'b0, 1'b1, 4'd8,  12'd2,    8'h81, 8'hFF, 1);
    run_frame(1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 4'd8,  12'd300,  8'h3C, 8'hA5, 1);
    run_frame(1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 4'd1,  12'd4095, 8'h01, 8'h80, 0);

    repeat (3) @(negedge clk);
    chk(rx_q.size() == 0, "R8", "all expected words received", rx_q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule